// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers level-sensitive interrupt sources into two CPU interrupt lines. Sources are arranged in three byte-wide groups: two local groups, each with a status byte and a mask byte, and one mappable group. The mappable group's status byte is gated by two separate mask bytes. Each of these two gated results is reduced to a single bit. The bit from map mask 0 replaces bit 7 of local group 0. The bit from map mask 1 replaces bit 3 of local group 1. This forms a two-level cascade. Each CPU line is the registered OR of its local group's unmasked status bits.

Software reaches the block through a simple byte-wide register port. Writes are strobed and take effect at the clock edge. Reads are combinational from the address. Status bytes always show the raw sampled inputs, whatever the masks hold. Software can therefore poll a status bit, such as a hardware-busy flag, without enabling it as an interrupt.

Source numbering is as follows:
- Sources 0 to 7 are local group 0.
- Sources 8 to 15 are local group 1.
- Sources 16 to 23 are the mappable status seen through map mask 0.
- Sources 24 to 31 are the same mappable status seen through map mask 1.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, all four mask bytes read 0x00 and both `irq_o` bits are 0.
- R2: The local group 0 status at address 0x00 and the local group 1 status at address 0x02 each return the source inputs sampled at the previous clock edge. The mask value has no effect on this. The only exceptions are the cascade bits, local0 bit 7 and local1 bit 3.
- R3: `irq_o[0]` equals the OR of (local0 status AND local0 mask), and `irq_o[1]` is the same for local1. A source change is latched into status at the first clock edge. The change then appears on `irq_o` after the second clock edge.
- R4: The local0 mask at 0x01 and the local1 mask at 0x03 are read/write and return the last value written.
- R5: The map status at address 0x04 returns the raw `map_src_i` value sampled at the previous edge.
- R6: Local0 status bit 7 reads as the OR of (map status AND map mask 0). Input `l0_src_i[7]` is ignored.
- R7: Local1 status bit 3 reads as the OR of (map status AND map mask 1). Input `l1_src_i[3]` is ignored.
- R8: Map mask 0 at 0x08 and map mask 1 at 0x0C (four bytes above) are independent read/write bytes. A write to one leaves the other unchanged.
- R9: Writes to the three status addresses (0x00, 0x02, 0x04) change no mask, and status continues to follow its inputs.
- R10: A read of any other address returns 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l0_src_i | input | 8 | Local group 0 source levels |
| l1_src_i | input | 8 | Local group 1 source levels |
| map_src_i | input | 8 | Mappable group source levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 2 | CPU interrupt lines: bit 0 from local0, bit 1 from local1 |

## Verification
The bench goes after the cascade bits in three ways:
- It drives the source input bits that the cascade overrides, so a design that let `l0_src_i[7]` or `l1_src_i[3]` through would show a stale status bit.
- It routes one map source through only one map mask, so a design that shared or swapped the map masks would raise the wrong CPU line.
- It checks that a mappable bit crossing two levels arrives with the same two-edge latency as a direct source. A design that registered the cascade bit would be one cycle late.

It also writes all ones to the status addresses and to unmapped addresses. A design that decoded those writes as mask writes, or that aliased a mask into the unmapped space, would show changed masks on readback.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int GRP_W  = 8;
    localparam int ADDR_W = 6;
    localparam int L0_CASC_BIT = 7;
    localparam int L1_CASC_BIT = 3;
    localparam int MAP_MASK_STRIDE = 4;

    localparam logic [ADDR_W-1:0] A_L0_STAT   = 6'h00;
    localparam logic [ADDR_W-1:0] A_L0_MASK   = 6'h01;
    localparam logic [ADDR_W-1:0] A_L1_STAT   = 6'h02;
    localparam logic [ADDR_W-1:0] A_L1_MASK   = 6'h03;
    localparam logic [ADDR_W-1:0] A_MAP_STAT  = 6'h04;
    localparam logic [ADDR_W-1:0] A_MAP_MASK0 = 6'h08;
    localparam logic [ADDR_W-1:0] A_MAP_MASK1 = A_MAP_MASK0 + ADDR_W'(MAP_MASK_STRIDE);

    function automatic int casc_pos(input int grp);
        return (grp == 0) ? L0_CASC_BIT : L1_CASC_BIT;
    endfunction
endpackage

// File: rtl/irq_local_group.sv
module irq_local_group #(
    parameter int W        = irq_pkg::GRP_W,
    parameter int CASC_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         casc_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] mask;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [W-1:0] view;

    always_comb begin
        st_d      = st_q;
        st_d.stat = src_i;
        if (mask_we_i) begin
            st_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        view           = st_q.stat;
        view[CASC_BIT] = casc_i;
    end

    assign status_o = view;
    assign mask_o   = st_q.mask;
    assign pend_o   = |(view & st_q.mask);

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_o)) else $error("mask changed without write"); // R4
endmodule

// File: rtl/irq_map_group.sv
module irq_map_group #(
    parameter int W = irq_pkg::GRP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         we0_i,
    input  logic         we1_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask0_o,
    output logic [W-1:0] mask1_o,
    output logic         casc0_o,
    output logic         casc1_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] m0;
        logic [W-1:0] m1;
    } map_state_t;

    map_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = src_i;
        if (we0_i) st_d.m0 = wdata_i;
        if (we1_i) st_d.m1 = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.stat;
    assign mask0_o = st_q.m0;
    assign mask1_o = st_q.m1;
    assign casc0_o = |(st_q.stat & st_q.m0);
    assign casc1_o = |(st_q.stat & st_q.m1);

    AST_MAP_MASK1_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we0_i && !we1_i) |=> $stable(mask1_o)) else $error("mask1 disturbed"); // R8
    AST_MAP_MASK0_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we1_i && !we0_i) |=> $stable(mask0_o)) else $error("mask0 disturbed"); // R8
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRP_W-1:0]  l0_src_i,
    input  logic [GRP_W-1:0]  l1_src_i,
    input  logic [GRP_W-1:0]  map_src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [GRP_W-1:0]  wdata_i,
    output logic [GRP_W-1:0]  rdata_o,
    output logic [1:0]        irq_o
);
    localparam int NGRP = 2;

    typedef struct packed {
        logic [NGRP-1:0] irq;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [GRP_W-1:0] lsrc   [NGRP];
    logic [GRP_W-1:0] lstat  [NGRP];
    logic [GRP_W-1:0] lmask  [NGRP];
    logic [NGRP-1:0]  lpend;
    logic [NGRP-1:0]  lmask_we;
    logic [NGRP-1:0]  casc;
    logic [GRP_W-1:0] map_stat, map_m0, map_m1;
    logic             map_we0, map_we1;

    assign lsrc[0]     = l0_src_i;
    assign lsrc[1]     = l1_src_i;
    assign lmask_we[0] = wr_en_i && (addr_i == A_L0_MASK);
    assign lmask_we[1] = wr_en_i && (addr_i == A_L1_MASK);
    assign map_we0     = wr_en_i && (addr_i == A_MAP_MASK0);
    assign map_we1     = wr_en_i && (addr_i == A_MAP_MASK1);

    irq_map_group #(.W(GRP_W)) u_map (
        .clk(clk), .rst_n(rst_n), .src_i(map_src_i),
        .we0_i(map_we0), .we1_i(map_we1), .wdata_i(wdata_i),
        .stat_o(map_stat), .mask0_o(map_m0), .mask1_o(map_m1),
        .casc0_o(casc[0]), .casc1_o(casc[1])
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_local
        irq_local_group #(.W(GRP_W), .CASC_BIT(casc_pos(g))) u_grp (
            .clk(clk), .rst_n(rst_n), .src_i(lsrc[g]), .casc_i(casc[g]),
            .mask_we_i(lmask_we[g]), .mask_wdata_i(wdata_i),
            .status_o(lstat[g]), .mask_o(lmask[g]), .pend_o(lpend[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = lpend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    always_comb begin
        case (addr_i)
            A_L0_STAT:   rdata_o = lstat[0];
            A_L0_MASK:   rdata_o = lmask[0];
            A_L1_STAT:   rdata_o = lstat[1];
            A_L1_MASK:   rdata_o = lmask[1];
            A_MAP_STAT:  rdata_o = map_stat;
            A_MAP_MASK0: rdata_o = map_m0;
            A_MAP_MASK1: rdata_o = map_m1;
            default:     rdata_o = '0;
        endcase
    end

    AST_IRQ0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask[0] == '0) |=> !irq_o[0]) else $error("irq0 with empty mask"); // R3
    AST_IRQ1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask[1] == '0) |=> !irq_o[1]) else $error("irq1 with empty mask"); // R3
    AST_CASC0_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_stat & map_m0) != '0) |-> lstat[0][L0_CASC_BIT]) else $error("cascade0 lost"); // R6
    AST_CASC1_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_stat & map_m1) == '0) |-> !lstat[1][L1_CASC_BIT]) else $error("cascade1 stray"); // R7
    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == A_L0_STAT || addr_i == A_L1_STAT || addr_i == A_MAP_STAT))
        |=> ($stable(lmask[0]) && $stable(lmask[1]) && $stable(map_m0) && $stable(map_m1)))
        else $error("status write touched a mask"); // R9
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] l0_src = '0, l1_src = '0, map_src = '0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cascade_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .l0_src_i(l0_src), .l1_src_i(l1_src),
        .map_src_i(map_src), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle2();
        @(posedge clk); @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(6'h01, d); chk("R1 l0 mask", d, 8'h00);
        rd(6'h03, d); chk("R1 l1 mask", d, 8'h00);
        rd(6'h08, d); chk("R1 map mask0", d, 8'h00);
        rd(6'h0C, d); chk("R1 map mask1", d, 8'h00);
        chk("R1 irq", {6'b0, irq}, 8'h00);
    endtask

    task automatic t_status_raw();
        logic [7:0] d;
        @(negedge clk);
        l0_src = 8'h65; l1_src = 8'h5A; map_src = 8'h00;
        @(posedge clk);
        rd(6'h00, d); chk("R2 l0 status", d, 8'h65);
        rd(6'h02, d); chk("R7 l1 status bit3 ignored", d, 8'h52);
        chk("R3 irq stays low, masks empty", {6'b0, irq}, 8'h00);
        @(negedge clk);
        l0_src = 8'h00; l1_src = 8'h00;
    endtask

    task automatic t_mask_rw();
        logic [7:0] d;
        wr(6'h01, 8'h3C); wr(6'h03, 8'hC1);
        wr(6'h08, 8'h0F); wr(6'h0C, 8'hF0);
        rd(6'h01, d); chk("R4 l0 mask", d, 8'h3C);
        rd(6'h03, d); chk("R4 l1 mask", d, 8'hC1);
        rd(6'h08, d); chk("R8 map mask0", d, 8'h0F);
        rd(6'h0C, d); chk("R8 map mask1", d, 8'hF0);
        wr(6'h08, 8'hA5);
        rd(6'h0C, d); chk("R8 mask1 unchanged by mask0 write", d, 8'hF0);
        rd(6'h08, d); chk("R8 mask0 new value", d, 8'hA5);
        wr(6'h01, 8'h00); wr(6'h03, 8'h00); wr(6'h08, 8'h00); wr(6'h0C, 8'h00);
    endtask

    task automatic t_irq_direct();
        wr(6'h01, 8'h01); wr(6'h03, 8'h80);
        @(negedge clk); l0_src = 8'h01;
        @(posedge clk); #1;
        chk("R3 irq0 not yet after first edge", {7'b0, irq[0]}, 8'h00);
        @(posedge clk); #1;
        chk("R3 irq0 after second edge", {7'b0, irq[0]}, 8'h01);
        @(negedge clk); l0_src = 8'h02;
        settle2();
        chk("R3 unmasked-off source gives no irq0", {7'b0, irq[0]}, 8'h00);
        @(negedge clk); l1_src = 8'h80;
        settle2();
        chk("R3 irq1 from local1", {6'b0, irq}, 8'h02);
        @(negedge clk); l0_src = 8'h00; l1_src = 8'h00;
        wr(6'h01, 8'h00); wr(6'h03, 8'h00);
    endtask

    task automatic t_cascade();
        logic [7:0] d;
        wr(6'h01, 8'h80); wr(6'h03, 8'h08); wr(6'h08, 8'h10);
        @(negedge clk); l0_src = 8'h80; l1_src = 8'h08; map_src = 8'h00;
        settle2();
        rd(6'h00, d); chk("R6 l0 src bit7 ignored", d, 8'h00);
        chk("R6 no irq from ignored bits", {6'b0, irq}, 8'h00);
        @(negedge clk); l0_src = 8'h00; l1_src = 8'h00; map_src = 8'h10;
        @(posedge clk); #1;
        chk("R6 irq0 not yet after first edge", {6'b0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R6 cascade raises irq0 only", {6'b0, irq}, 8'h01);
        rd(6'h00, d); chk("R6 l0 status bit7", d, 8'h80);
        rd(6'h02, d); chk("R7 l1 bit3 clear with mask1 empty", d, 8'h00);
        rd(6'h04, d); chk("R5 map status", d, 8'h10);
        wr(6'h08, 8'h00); wr(6'h0C, 8'h10);
        @(posedge clk); #1;
        rd(6'h02, d); chk("R7 l1 status bit3", d, 8'h08);
        chk("R7 cascade moves to irq1", {6'b0, irq}, 8'h02);
        @(negedge clk); map_src = 8'h00;
        wr(6'h01, 8'h00); wr(6'h03, 8'h00); wr(6'h0C, 8'h00);
    endtask

    task automatic t_status_write();
        logic [7:0] d;
        wr(6'h01, 8'h11); wr(6'h03, 8'h22); wr(6'h08, 8'h33); wr(6'h0C, 8'h44);
        @(negedge clk); l0_src = 8'h06; map_src = 8'h40;
        wr(6'h00, 8'hFF); wr(6'h02, 8'hFF); wr(6'h04, 8'hFF);
        rd(6'h01, d); chk("R9 l0 mask kept", d, 8'h11);
        rd(6'h03, d); chk("R9 l1 mask kept", d, 8'h22);
        rd(6'h08, d); chk("R9 map mask0 kept", d, 8'h33);
        rd(6'h0C, d); chk("R9 map mask1 kept", d, 8'h44);
        rd(6'h00, d); chk("R9 l0 status follows input", d, 8'h06);
        rd(6'h04, d); chk("R9 map status follows input", d, 8'h40);
        @(negedge clk); l0_src = 8'h00; map_src = 8'h00;
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(6'h05, 8'hFF); wr(6'h3F, 8'hFF); wr(6'h09, 8'hFF);
        rd(6'h05, d); chk("R10 read 0x05", d, 8'h00);
        rd(6'h3F, d); chk("R10 read 0x3F", d, 8'h00);
        rd(6'h09, d); chk("R10 read 0x09", d, 8'h00);
        rd(6'h01, d); chk("R10 l0 mask kept", d, 8'h11);
        rd(6'h08, d); chk("R10 map mask0 kept", d, 8'h33);
        rd(6'h0C, d); chk("R10 map mask1 kept", d, 8'h44);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_status_raw();
        t_mask_rw();
        t_irq_direct();
        t_cascade();
        t_status_write();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule